// File: doc/BRIEF.md
# Hardware/Software Event Bridge

This block passes events, each with a data value, between a hardware state machine domain and a processor's memory-mapped register bus. Every event has one sender and may have any number of receivers. A sender never waits for a receiver and never checks on one. If the same event is sent again before it has been consumed, the new value replaces the old one.

In the hardware-to-software direction, each incoming event latches its value and sets a pending flag. Software either polls the flags or enables an interrupt for them. It then reads the value and clears the flag with a write-one-to-clear acknowledge. Software can also take a snapshot of all pending flags in a single write. The snapshot then stays stable while software reacts to it, and the live flags keep collecting new events.

In the software-to-hardware direction, software first writes a value register and then raises a flag bit. A rising-edge detector turns the flag into a strobe that lasts exactly one cycle, however long software holds the flag. The value output holds until software writes it again. All state lives in a single clock domain.

Top module: `evt_bridge`

## Requirements
- R1: A hardware event on lane i (`hw_evt_vld[i]`=1) sets pending flag i and latches that lane's value in the same clock edge. It does so whatever the flag's prior state, so a repeated event keeps only the latest value, which is readable at address 4+i.
- R2: A bus write to address 0 clears every pending flag whose data bit is 1 (bit i controls lane i). Flags whose data bit is 0 are left unchanged.
- R3: When an acknowledge or a snapshot and a hardware event on the same lane arrive in the same cycle, the event wins: the flag stays set and the value is updated.
- R4: A bus write to address 1 with data bit 0 set copies the pending flags into the snapshot register, readable at address 1 (bit i = lane i), and clears the pending flags in the same edge. The snapshot then holds until the next such write.
- R5: `irq` is high exactly when a pending flag is set whose enable bit is set. The enables are written and read at address 2, with bit i for lane i. `irq` therefore stays high until every enabled pending flag is cleared.
- R6: A bus write to address 4+NH+j sets software-to-hardware value j. The value appears on `sw_evt_val[j*DW +: DW]` after that edge and holds until the next write to that address.
- R7: Address 3 holds the software-to-hardware flags, with bit j for lane j. A 0-to-1 change of flag j drives `sw_evt_stb[j]` high for exactly the one cycle after the write edge. Holding the flag at 1 gives no further strobe.
- R8: Pending flags read at address 0. Reads of unmapped addresses return 0. Writes to unmapped addresses change no state.
- R9: After reset all flags, snapshots, enables and values are 0, `irq` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt_vld | input | NH | One-cycle hardware event pulses, one per lane |
| hw_evt_val | input | NH*DW | Values for the hardware events, lane i at bits i*DW |
| sw_evt_stb | output | NS | One-cycle strobes for software-to-hardware events |
| sw_evt_val | output | NS*DW | Software-written values, lane j at bits j*DW |
| bus_we | input | 1 | Write enable for the register bus |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: NH=4, NS=2, DW=8 and AW=4. With AW=4 the ten mapped registers and six unmapped addresses all fall inside one 16-entry space, so random addressing reaches every decode path, including the ignored writes. Four hardware lanes are enough to mix acknowledges of some bits with live events on others. Two software lanes are enough to show that each strobe is independent of the other lane's flag.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int unsigned A_STAT     = 0;
    localparam int unsigned A_FRZ      = 1;
    localparam int unsigned A_IE       = 2;
    localparam int unsigned A_FLAG     = 3;
    localparam int unsigned A_VAL_BASE = 4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_FRZ,
        RK_IE,
        RK_FLAG,
        RK_HVAL,
        RK_SVAL
    } reg_kind_e;

    function automatic reg_kind_e decode_kind(input logic [31:0] a,
                                              input int unsigned nh,
                                              input int unsigned ns);
        reg_kind_e k;
        k = RK_NONE;
        if (a == A_STAT)                           k = RK_STAT;
        else if (a == A_FRZ)                       k = RK_FRZ;
        else if (a == A_IE)                        k = RK_IE;
        else if (a == A_FLAG)                      k = RK_FLAG;
        else if (a >= A_VAL_BASE && a < A_VAL_BASE + nh)
                                                   k = RK_HVAL;
        else if (a >= A_VAL_BASE + nh && a < A_VAL_BASE + nh + ns)
                                                   k = RK_SVAL;
        return k;
    endfunction

endpackage

// File: rtl/evt_h2s_lane.sv
module evt_h2s_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_vld,
    input  logic [DW-1:0] evt_val,
    input  logic          ack,
    input  logic          freeze,
    output logic          stat,
    output logic          frz,
    output logic [DW-1:0] val
);

    typedef struct packed {
        logic          stat;
        logic          frz;
        logic [DW-1:0] val;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (freeze)
            st_d.frz = st_q.stat;
        if (evt_vld) begin
            st_d.stat = 1'b1;
            st_d.val  = evt_val;
        end else if (ack || freeze) begin
            st_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign frz  = st_q.frz;
    assign val  = st_q.val;

endmodule

// File: rtl/evt_s2h_lane.sv
module evt_s2h_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          val_we,
    input  logic [DW-1:0] wdata,
    input  logic          flag_we,
    input  logic          flag_bit,
    output logic          flag,
    output logic          stb,
    output logic [DW-1:0] val
);

    typedef struct packed {
        logic [DW-1:0] val;
        logic          flag;
        logic          prev;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = st_q.flag;
        if (flag_we) st_d.flag = flag_bit;
        if (val_we)  st_d.val  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign stb  = st_q.flag & ~st_q.prev;
    assign val  = st_q.val;

endmodule

// File: rtl/evt_regif.sv
module evt_regif
    import evt_pkg::*;
#(
    parameter int NH = 4,
    parameter int NS = 2,
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NH-1:0]    stat,
    input  logic [NH-1:0]    frz,
    input  logic [NH*DW-1:0] hval,
    input  logic [NS-1:0]    flag,
    input  logic [NS*DW-1:0] sval,
    output logic [NH-1:0]    ack_mask,
    output logic             freeze,
    output logic [NH-1:0]    ie,
    output logic             flag_we,
    output logic [NS-1:0]    sval_we
);

    typedef struct packed {
        logic [NH-1:0] ie;
    } rif_t;

    rif_t        st_d, st_q;
    logic [31:0] a;
    logic [31:0] hidx;
    logic [31:0] sidx;
    reg_kind_e   kind;

    always_comb begin
        a         = 32'(bus_addr);
        kind      = decode_kind(a, NH, NS);
        hidx      = a - A_VAL_BASE;
        sidx      = a - A_VAL_BASE - NH;
        st_d      = st_q;
        ack_mask  = '0;
        freeze    = 1'b0;
        flag_we   = 1'b0;
        sval_we   = '0;
        bus_rdata = '0;
        unique case (kind)
            RK_STAT: begin
                bus_rdata[NH-1:0] = stat;
                if (bus_we) ack_mask = bus_wdata[NH-1:0];
            end
            RK_FRZ: begin
                bus_rdata[NH-1:0] = frz;
                freeze = bus_we & bus_wdata[0];
            end
            RK_IE: begin
                bus_rdata[NH-1:0] = st_q.ie;
                if (bus_we) st_d.ie = bus_wdata[NH-1:0];
            end
            RK_FLAG: begin
                bus_rdata[NS-1:0] = flag;
                flag_we = bus_we;
            end
            RK_HVAL: begin
                for (int i = 0; i < NH; i++)
                    if (hidx == i) bus_rdata = hval[i*DW +: DW];
            end
            RK_SVAL: begin
                for (int j = 0; j < NS; j++)
                    if (sidx == j) begin
                        bus_rdata  = sval[j*DW +: DW];
                        sval_we[j] = bus_we;
                    end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie = st_q.ie;

endmodule

// File: rtl/evt_bridge.sv
module evt_bridge
    import evt_pkg::*;
#(
    parameter int NH = 4,
    parameter int NS = 2,
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NH-1:0]    hw_evt_vld,
    input  logic [NH*DW-1:0] hw_evt_val,
    output logic [NS-1:0]    sw_evt_stb,
    output logic [NS*DW-1:0] sw_evt_val,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq
);

    localparam int NREG = A_VAL_BASE + NH + NS;

    initial begin
        if (NREG > (1 << AW)) $error("address space too small for register map");
        if (NH > DW || NS > DW) $error("lane count exceeds data width");
    end

    logic [NH-1:0]    act_stat;
    logic [NH-1:0]    frz_stat;
    logic [NH-1:0]    ie_mask;
    logic [NH-1:0]    ack_mask;
    logic             freeze;
    logic [NH*DW-1:0] hval;
    logic [NS-1:0]    flag;
    logic             flag_we;
    logic [NS-1:0]    sval_we;

    evt_regif #(.NH(NH), .NS(NS), .DW(DW), .AW(AW)) u_rif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat      (act_stat),
        .frz       (frz_stat),
        .hval      (hval),
        .flag      (flag),
        .sval      (sw_evt_val),
        .ack_mask  (ack_mask),
        .freeze    (freeze),
        .ie        (ie_mask),
        .flag_we   (flag_we),
        .sval_we   (sval_we)
    );

    for (genvar i = 0; i < NH; i++) begin : g_h2s
        evt_h2s_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_vld (hw_evt_vld[i]),
            .evt_val (hw_evt_val[i*DW +: DW]),
            .ack     (ack_mask[i]),
            .freeze  (freeze),
            .stat    (act_stat[i]),
            .frz     (frz_stat[i]),
            .val     (hval[i*DW +: DW])
        );
    end

    for (genvar j = 0; j < NS; j++) begin : g_s2h
        evt_s2h_lane #(.DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .val_we   (sval_we[j]),
            .wdata    (bus_wdata),
            .flag_we  (flag_we),
            .flag_bit (bus_wdata[j]),
            .flag     (flag[j]),
            .stb      (sw_evt_stb[j]),
            .val      (sw_evt_val[j*DW +: DW])
        );
    end

    assign irq = |(act_stat & ie_mask);

endmodule

// File: rtl/evt_bridge_chk.sv
module evt_bridge_chk #(
    parameter int NH = 4,
    parameter int NS = 2,
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NH-1:0]    hw_evt_vld,
    input logic [NS-1:0]    sw_evt_stb,
    input logic [NS*DW-1:0] sw_evt_val,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             irq,
    input logic [NH-1:0]    act_stat,
    input logic [NH-1:0]    frz_stat
);

    localparam int unsigned SBASE = 4 + NH;

    logic [31:0] a;
    logic        wr_frz;
    logic        wr_sval;
    assign a       = 32'(bus_addr);
    assign wr_frz  = bus_we && a == 1 && bus_wdata[0];
    assign wr_sval = bus_we && a >= SBASE && a < SBASE + NS;

    for (genvar i = 0; i < NH; i++) begin : g_h
        assert_evt_sets_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
            hw_evt_vld[i] |=> act_stat[i]);
        assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && a == 0 && bus_wdata[i] && !hw_evt_vld[i]) |=> !act_stat[i]);
    end

    assert_freeze_snapshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_frz |=> (frz_stat == $past(act_stat)) && (act_stat == $past(hw_evt_vld)));

    assert_frozen_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_frz |=> $stable(frz_stat));

    assert_irq_falls_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_we));

    assert_sval_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sval |=> $stable(sw_evt_val));

    for (genvar j = 0; j < NS; j++) begin : g_s
        assert_one_cycle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sw_evt_stb[j] |=> !sw_evt_stb[j]);
    end

endmodule

bind evt_bridge evt_bridge_chk #(.NH(NH), .NS(NS), .DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_evt_vld (hw_evt_vld),
    .sw_evt_stb (sw_evt_stb),
    .sw_evt_val (sw_evt_val),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .act_stat   (act_stat),
    .frz_stat   (frz_stat)
);

// File: tb/sim_evt_bridge.sv
module sim_evt_bridge;

    localparam int NH = 4;
    localparam int NS = 2;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int SB = 4 + NH;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NH-1:0]    hw_evt_vld;
    logic [NH*DW-1:0] hw_evt_val;
    logic [NS-1:0]    sw_evt_stb;
    logic [NS*DW-1:0] sw_evt_val;
    logic             bus_we;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_wdata;
    logic [DW-1:0]    bus_rdata;
    logic             irq;

    always #4 clk = ~clk;

    evt_bridge #(.NH(NH), .NS(NS), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_evt_vld(hw_evt_vld), .hw_evt_val(hw_evt_val),
        .sw_evt_stb(sw_evt_stb), .sw_evt_val(sw_evt_val), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int errs   = 0;
    int checks = 0;

    logic [NH-1:0] m_stat, m_frz, m_ie;
    logic [DW-1:0] m_hval [NH];
    logic [NS-1:0] m_flag, m_prev;
    logic [DW-1:0] m_sval [NS];

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input int a);
        logic [DW-1:0] r;
        r = '0;
        if (a == 0)                    r[NH-1:0] = m_stat;
        else if (a == 1)               r[NH-1:0] = m_frz;
        else if (a == 2)               r[NH-1:0] = m_ie;
        else if (a == 3)               r[NS-1:0] = m_flag;
        else if (a >= 4 && a < SB)     r = m_hval[a-4];
        else if (a >= SB && a < SB+NS) r = m_sval[a-SB];
        return r;
    endfunction

    task automatic model_reset();
        m_stat = '0; m_frz = '0; m_ie = '0; m_flag = '0; m_prev = '0;
        for (int i = 0; i < NH; i++) m_hval[i] = '0;
        for (int j = 0; j < NS; j++) m_sval[j] = '0;
    endtask

    task automatic model_clock();
        int a;
        logic [NH-1:0] ack;
        logic frz;
        a   = int'(bus_addr);
        ack = (bus_we && a == 0) ? bus_wdata[NH-1:0] : '0;
        frz = bus_we && a == 1 && bus_wdata[0];
        if (frz) m_frz = m_stat;
        for (int i = 0; i < NH; i++) begin
            if (hw_evt_vld[i]) begin
                m_stat[i] = 1'b1;
                m_hval[i] = hw_evt_val[i*DW +: DW];
            end else if (ack[i] || frz) begin
                m_stat[i] = 1'b0;
            end
        end
        if (bus_we && a == 2) m_ie = bus_wdata[NH-1:0];
        m_prev = m_flag;
        if (bus_we && a == 3) m_flag = bus_wdata[NS-1:0];
        for (int j = 0; j < NS; j++)
            if (bus_we && a == SB + j) m_sval[j] = bus_wdata;
    endtask

    task automatic compare_all();
        chk("R5", "irq", 32'(irq), 32'(|(m_stat & m_ie)));
        chk("R7", "strobe", 32'(sw_evt_stb), 32'(m_flag & ~m_prev));
        for (int j = 0; j < NS; j++)
            chk("R6", "sw value", 32'(sw_evt_val[j*DW +: DW]), 32'(m_sval[j]));
        chk("R8", "read data", 32'(bus_rdata), 32'(exp_read(int'(bus_addr))));
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        #1;
        compare_all();
    endtask

    task automatic drive(input logic [NH-1:0] v, input logic [NH*DW-1:0] vals,
                         input logic we, input int a, input logic [DW-1:0] wd);
        hw_evt_vld = v;
        hw_evt_val = vals;
        bus_we     = we;
        bus_addr   = AW'(a);
        bus_wdata  = wd;
        step();
        hw_evt_vld = '0;
        bus_we     = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        bus_we   = 1'b0;
        bus_addr = AW'(a);
        hw_evt_vld = '0;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd6061));
        rst_n = 1'b0; hw_evt_vld = '0; hw_evt_val = '0;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9: reset values across the whole map
        for (int a = 0; a < (1 << AW); a++) begin
            rd(a, d);
            chk("R9", "reset read", 32'(d), 32'd0);
        end
        chk("R9", "reset irq", 32'(irq), 0);
        chk("R9", "reset strobe", 32'(sw_evt_stb), 0);

        // R1: second event overwrites unconsumed value
        drive(4'b0001, {24'h0, 8'h11}, 1'b0, 4, 8'h00);
        drive(4'b0001, {24'h0, 8'h22}, 1'b0, 4, 8'h00);
        rd(4, d); chk("R1", "latest value lane0", 32'(d), 32'h22);
        rd(0, d); chk("R1", "status lane0", 32'(d), 32'h01);

        // R5: interrupt enable and hold until acknowledged
        drive('0, '0, 1'b1, 2, 8'h01);
        chk("R5", "irq asserted", 32'(irq), 1);
        drive('0, '0, 1'b0, 2, 8'h00);
        chk("R5", "irq held", 32'(irq), 1);
        drive('0, '0, 1'b1, 0, 8'h01);
        chk("R5", "irq cleared by ack", 32'(irq), 0);

        // R3: event and ack on same lane in same cycle
        drive(4'b0010, {16'h0, 8'h3C, 8'h0}, 1'b1, 0, 8'h02);
        rd(0, d); chk("R3", "status survives ack", 32'(d), 32'h02);
        rd(5, d); chk("R3", "value updated", 32'(d), 32'h3C);

        // R2: partial acknowledge
        drive(4'b1000, {8'h77, 24'h0}, 1'b0, 0, 8'h00);
        drive('0, '0, 1'b1, 0, 8'h08);
        rd(0, d); chk("R2", "only lane3 cleared", 32'(d), 32'h02);

        // R4: snapshot with a simultaneous event on lane2
        drive(4'b0100, {8'h0, 8'h5E, 16'h0}, 1'b1, 1, 8'h01);
        rd(1, d); chk("R4", "frozen copy", 32'(d), 32'h02);
        rd(0, d); chk("R4", "active after freeze", 32'(d), 32'h04);
        drive(4'b0001, {24'h0, 8'h99}, 1'b0, 1, 8'h00);
        rd(1, d); chk("R4", "frozen stable", 32'(d), 32'h02);

        // R6: software value holds across unrelated writes
        drive('0, '0, 1'b1, SB, 8'h5A);
        drive('0, '0, 1'b1, 2, 8'h00);
        drive('0, '0, 1'b1, 3, 8'h00);
        chk("R6", "value held", 32'(sw_evt_val[DW-1:0]), 32'h5A);

        // R7: flag held several cycles yields one strobe
        drive('0, '0, 1'b1, 3, 8'h01);
        chk("R7", "strobe after rise", 32'(sw_evt_stb), 32'h1);
        drive('0, '0, 1'b0, 3, 8'h00);
        chk("R7", "strobe gone while held", 32'(sw_evt_stb), 32'h0);
        drive('0, '0, 1'b1, 3, 8'h03);
        chk("R7", "strobe lane1 only", 32'(sw_evt_stb), 32'h2);
        drive('0, '0, 1'b1, 3, 8'h00);
        drive('0, '0, 1'b1, 3, 8'h01);
        chk("R7", "strobe on second rise", 32'(sw_evt_stb), 32'h1);

        // R8: unmapped write ignored, unmapped read zero
        drive('0, '0, 1'b1, 12, 8'hFF);
        rd(12, d); chk("R8", "unmapped read", 32'(d), 32'h0);
        rd(0, d);  chk("R8", "status unchanged", 32'(d), 32'(exp_read(0)));

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [NH-1:0] v;
            v = NH'($urandom) & NH'($urandom);
            drive(v, (NH*DW)'({$urandom, $urandom}), 1'($urandom),
                  int'($urandom_range(0, (1 << AW) - 1)), DW'($urandom));
        end

        finish_run();
    end

endmodule